// File: doc/BRIEF.md
# Accelerator Register Bus Slave

This block sits between a host processor's simple register bus and a bank of user registers held inside an accelerator. The host presents a byte address, a status word, and write data. The block decodes the address against a contiguous window of word slots. It raises a one-cycle write enable for the addressed register, and the accelerator loads the write data on that enable. For reads, every register value is gated to zero unless its slot was addressed on the previous cycle. The gated values are widened to the bus width and combined by a wide OR onto the read data output.

One slot beyond the last user register is reserved as the start slot. Addressing it pulses the start output one cycle later, and during that cycle the read data carries the accelerator's done flag in bit 0. Writes are accepted only while the accelerator reports done and the top address bit (the memory-window select) is clear. The register list is laid out in ascending address order: register k lives at word `BASE + k` and the start slot at word `BASE + NREG`.

Top module: `rb_regbus`

## Requirements
- R1: `reg_we_o[k]` is high in the same cycle exactly when `stat_i[0]` is 1, the word field `addr_i[LSB +: FIELD_W]` equals `BASE + k`, `done_i` is 1, and `addr_i[ADDR_W-1]` is 0. `FIELD_W` is the bit count needed to hold `BASE + NREG`.
- R2: While `done_i` is 0, no write enable is raised and no register value changes, whatever the other inputs are.
- R3: While the memory-window bit `addr_i[ADDR_W-1]` is 1, no write enable is raised and no register value changes.
- R4: `reg_wdata_o` always equals the low `REG_W` bits of `wdata_i`. Upper bus bits never reach a register.
- R5: When register slot k was addressed in cycle t, `rdata_o` in cycle t+1 equals that register's current value, zero-extended to `DATA_W` bits.
- R6: When the word field addressed in cycle t matches no slot (below `BASE` or above `BASE + NREG`), `rdata_o` is all zeros in cycle t+1.
- R7: When the start slot was addressed in cycle t, `start_o` is 1 in cycle t+1, and `rdata_o` then equals the current `done_i` in bit 0 with all other bits zero. In every other cycle `start_o` is 0.
- R8: While `rst_n` is low, `rdata_o` is zero and `start_o` is 0.
- R9: At most one bit of `reg_we_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Host byte address; the top bit selects the memory window |
| stat_i | input | STAT_W | Host status word; bit 0 is the write strobe |
| wdata_i | input | DATA_W | Host write data |
| done_i | input | 1 | Accelerator done flag |
| reg_val_i | input | NREG*REG_W | Current register values, register k at bits [k*REG_W +: REG_W] |
| reg_we_o | output | NREG | Per-register write enables |
| reg_wdata_o | output | REG_W | Write data for the registers |
| start_o | output | 1 | Start pulse, one cycle after the start slot is addressed |
| rdata_o | output | DATA_W | OR-combined read data |

## Verification
The bench builds the block with six registers of 12 bits on a 32-bit data bus, at the default base word 0x8000 with byte addressing. The narrow registers make zero-extension and the truncation of write data visible on every transfer. The short bank puts the start slot and the unmapped words on both sides of the window within a few addresses. This lets a mix of directed and random traffic cover blocked writes, the read latency, start-slot reads while done changes, and aliasing-free decoding.

// File: rtl/rb_pkg.sv
package rb_pkg;

  // Bits needed to represent the highest decoded word index.
  function automatic int field_width(input int unsigned base, input int unsigned nreg);
    return $clog2(base + nreg + 1);
  endfunction

endpackage

// File: rtl/rb_addr_decode.sv
module rb_addr_decode #(
  parameter int          FIELD_W = 16,
  parameter int unsigned BASE    = 32'h8000,
  parameter int          NSLOT   = 11
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [NSLOT-1:0]   hit_o
);

  // One comparator per word slot, slots at consecutive word indices.
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [FIELD_W-1:0] SLOT_ADDR = FIELD_W'(BASE + k);
    assign hit_o[k] = (field_i == SLOT_ADDR);
  end

endmodule

// File: rtl/rb_write_gate.sv
module rb_write_gate #(
  parameter int NREG = 10
) (
  input  logic [NREG-1:0] hit_i,
  input  logic            strobe_i,
  input  logic            done_i,
  input  logic            mem_sel_i,
  output logic [NREG-1:0] we_o
);

  logic mem_sel_n;
  assign mem_sel_n = ~mem_sel_i;

  // Four-term qualification per register.
  for (genvar k = 0; k < NREG; k++) begin : g_we
    assign we_o[k] = strobe_i & hit_i[k] & done_i & mem_sel_n;
  end

endmodule

// File: rtl/rb_read_merge.sv
module rb_read_merge #(
  parameter int NREG   = 10,
  parameter int REG_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic [NREG-1:0]       sel_q_i,
  input  logic                  start_q_i,
  input  logic                  done_i,
  input  logic [NREG*REG_W-1:0] reg_val_i,
  output logic [DATA_W-1:0]     rdata_o
);

  logic [DATA_W-1:0] gated [NREG+1];

  // Zero-gate and widen each register value.
  for (genvar k = 0; k < NREG; k++) begin : g_gate
    logic [REG_W-1:0] val;
    assign val      = reg_val_i[k*REG_W +: REG_W];
    assign gated[k] = sel_q_i[k] ? DATA_W'(val) : '0;
  end

  // Extra term for the start slot carries the done flag.
  assign gated[NREG] = start_q_i ? DATA_W'(done_i) : '0;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k <= NREG; k++) begin
      rdata_o = rdata_o | gated[k];
    end
  end

endmodule

// File: rtl/rb_regbus.sv
module rb_regbus #(
  parameter int          ADDR_W = 32,
  parameter int          STAT_W = 8,
  parameter int          DATA_W = 32,
  parameter int          REG_W  = 32,
  parameter int          NREG   = 10,
  parameter int          LSB    = 2,
  parameter int unsigned BASE   = 32'h8000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [STAT_W-1:0]     stat_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  done_i,
  input  logic [NREG*REG_W-1:0] reg_val_i,
  output logic [NREG-1:0]       reg_we_o,
  output logic [REG_W-1:0]      reg_wdata_o,
  output logic                  start_o,
  output logic [DATA_W-1:0]     rdata_o
);

  localparam int FIELD_W = rb_pkg::field_width(BASE, NREG);
  localparam int NSLOT   = NREG + 1;
  localparam int MEM_BIT = ADDR_W - 1;
  localparam int START_K = NREG;

  logic [FIELD_W-1:0] field;
  logic [NSLOT-1:0]   hit;
  logic [NSLOT-1:0]   sel_d;
  logic [NSLOT-1:0]   sel_q;
  logic               unused_bits;

  assign field       = addr_i[LSB +: FIELD_W];
  assign unused_bits = ^{addr_i, stat_i, wdata_i};

  rb_addr_decode #(
    .FIELD_W (FIELD_W),
    .BASE    (BASE),
    .NSLOT   (NSLOT)
  ) dec_i (
    .field_i (field),
    .hit_o   (hit)
  );

  rb_write_gate #(
    .NREG (NREG)
  ) wgate_i (
    .hit_i     (hit[NREG-1:0]),
    .strobe_i  (stat_i[0]),
    .done_i    (done_i),
    .mem_sel_i (addr_i[MEM_BIT]),
    .we_o      (reg_we_o)
  );

  assign reg_wdata_o = wdata_i[REG_W-1:0];

  // Read-side decode is registered: next-state then register.
  always_comb begin
    sel_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign start_o = sel_q[START_K];

  rb_read_merge #(
    .NREG   (NREG),
    .REG_W  (REG_W),
    .DATA_W (DATA_W)
  ) rmerge_i (
    .sel_q_i   (sel_q[NREG-1:0]),
    .start_q_i (sel_q[START_K]),
    .done_i    (done_i),
    .reg_val_i (reg_val_i),
    .rdata_o   (rdata_o)
  );

endmodule

// File: rtl/rb_regbus_chk.sv
module rb_regbus_chk #(
  parameter int          ADDR_W  = 32,
  parameter int          STAT_W  = 8,
  parameter int          DATA_W  = 32,
  parameter int          NREG    = 10,
  parameter int          LSB     = 2,
  parameter int          FIELD_W = 16,
  parameter int unsigned BASE    = 32'h8000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic [STAT_W-1:0] stat_i,
  input logic              done_i,
  input logic [NREG-1:0]   reg_we_o,
  input logic              start_o,
  input logic [DATA_W-1:0] rdata_o
);

  logic [FIELD_W-1:0] fld;
  logic               at_start;
  logic               off_map;
  assign fld      = addr_i[LSB +: FIELD_W];
  assign at_start = (fld == FIELD_W'(BASE + NREG));
  assign off_map  = (fld < FIELD_W'(BASE)) || (fld > FIELD_W'(BASE + NREG));

  a_r9_single_we: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_we_o));

  a_r2_done_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |-> (reg_we_o == '0));

  a_r3_mem_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    addr_i[ADDR_W-1] |-> (reg_we_o == '0));

  a_r1_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_i[0] |-> (reg_we_o == '0));

  a_r7_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
    at_start |=> start_o);

  a_r7_start_only: assert property (@(posedge clk) disable iff (!rst_n)
    !at_start |=> !start_o);

  a_r7_done_term: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (rdata_o == DATA_W'(done_i)));

  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    off_map |=> (rdata_o == '0));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_reset_quiet: assert (!start_o && rdata_o == '0);
    end
  end

endmodule

bind rb_regbus rb_regbus_chk #(
  .ADDR_W  (ADDR_W),
  .STAT_W  (STAT_W),
  .DATA_W  (DATA_W),
  .NREG    (NREG),
  .LSB     (LSB),
  .FIELD_W (FIELD_W),
  .BASE    (BASE)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr_i   (addr_i),
  .stat_i   (stat_i),
  .done_i   (done_i),
  .reg_we_o (reg_we_o),
  .start_o  (start_o),
  .rdata_o  (rdata_o)
);

// File: tb/rb_regbus_tb.sv
module rb_regbus_tb_top;

  localparam int          ADDR_W = 32;
  localparam int          STAT_W = 8;
  localparam int          DATA_W = 32;
  localparam int          REG_W  = 12;
  localparam int          NREG   = 6;
  localparam int          LSB    = 2;
  localparam int unsigned BASE   = 32'h8000;

  logic                  clk;
  logic                  rst_n;
  logic [ADDR_W-1:0]     addr_i;
  logic [STAT_W-1:0]     stat_i;
  logic [DATA_W-1:0]     wdata_i;
  logic                  done_i;
  logic [NREG*REG_W-1:0] reg_val_i;
  logic [NREG-1:0]       reg_we_o;
  logic [REG_W-1:0]      reg_wdata_o;
  logic                  start_o;
  logic [DATA_W-1:0]     rdata_o;

  int vectors;
  int miscompares;
  bit finished;

  // Behavioural model state
  logic [REG_W-1:0] model_regs [NREG];
  int               prev_idx;

  rb_regbus #(
    .ADDR_W (ADDR_W), .STAT_W (STAT_W), .DATA_W (DATA_W), .REG_W (REG_W),
    .NREG (NREG), .LSB (LSB), .BASE (BASE)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .addr_i (addr_i), .stat_i (stat_i),
    .wdata_i (wdata_i), .done_i (done_i), .reg_val_i (reg_val_i),
    .reg_we_o (reg_we_o), .reg_wdata_o (reg_wdata_o), .start_o (start_o),
    .rdata_o (rdata_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Slot index of an address: 0..NREG-1 register, NREG start, -1 none.
  function automatic int slot_of(input logic [ADDR_W-1:0] a);
    int unsigned w;
    w = (a >> LSB) & 32'hFFFF;
    if (w >= BASE && w <= BASE + NREG) return int'(w - BASE);
    return -1;
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input int unsigned w);
    return ADDR_W'(w << LSB);
  endfunction

  function automatic logic [NREG-1:0] exp_we();
    int s;
    logic [NREG-1:0] v;
    v = '0;
    s = slot_of(addr_i);
    if (stat_i[0] && done_i && !addr_i[ADDR_W-1] && s >= 0 && s < NREG) v[s] = 1'b1;
    return v;
  endfunction

  always_comb begin
    for (int k = 0; k < NREG; k++) reg_val_i[k*REG_W +: REG_W] = model_regs[k];
  end

  // The accelerator's registers, loaded from the model's expected enables.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_idx <= -1;
    end else begin
      logic [NREG-1:0] we;
      we = exp_we();
      for (int k = 0; k < NREG; k++)
        if (we[k]) model_regs[k] <= wdata_i[REG_W-1:0];
      prev_idx <= slot_of(addr_i);
    end
  end

  task automatic check_outputs(input string tag);
    logic [DATA_W-1:0] er;
    logic              es;
    logic [NREG-1:0]   ew;
    er = '0;
    es = 1'b0;
    ew = rst_n ? exp_we() : '0;
    if (!rst_n) begin
      er = '0;
    end else if (prev_idx >= 0 && prev_idx < NREG) begin
      er = DATA_W'(model_regs[prev_idx]);
    end else if (prev_idx == NREG) begin
      er = DATA_W'(done_i);
      es = 1'b1;
    end
    vectors++;
    if (rst_n && reg_we_o !== ew) begin
      miscompares++;
      $display("FAIL R1/R9 %s: reg_we_o=%b expected %b", tag, reg_we_o, ew);
    end
    if (reg_wdata_o !== wdata_i[REG_W-1:0]) begin
      miscompares++;
      $display("FAIL R4 %s: reg_wdata_o=%h expected %h", tag, reg_wdata_o, wdata_i[REG_W-1:0]);
    end
    if (rdata_o !== er) begin
      miscompares++;
      $display("FAIL R5/R6/R8 %s: rdata_o=%h expected %h", tag, rdata_o, er);
    end
    if (start_o !== es) begin
      miscompares++;
      $display("FAIL R7 %s: start_o=%b expected %b", tag, start_o, es);
    end
  endtask

  task automatic step(input logic [ADDR_W-1:0] a, input logic [STAT_W-1:0] s,
                      input logic [DATA_W-1:0] d, input logic dn, input string tag);
    @(negedge clk);
    addr_i  = a;
    stat_i  = s;
    wdata_i = d;
    done_i  = dn;
    #1;
    check_outputs(tag);
  endtask

  // Directed write then read-back of one register
  task automatic wr(input int k, input logic [DATA_W-1:0] d, input logic dn,
                    input logic mem, input string tag);
    logic [ADDR_W-1:0] a;
    a = word_addr(BASE + k);
    a[ADDR_W-1] = mem;
    step(a, 8'h01, d, dn, tag);
  endtask

  task automatic rd(input int k, input logic dn, input string tag);
    step(word_addr(BASE + k), 8'hFE, 32'hFFFF_FFFF, dn, tag);
  endtask

  initial begin
    vectors     = 0;
    miscompares = 0;
    finished    = 0;
    for (int k = 0; k < NREG; k++) model_regs[k] = '0;
    rst_n   = 1'b0;
    addr_i  = word_addr(BASE);
    stat_i  = 8'h01;
    wdata_i = 32'h0000_0ABC;
    done_i  = 1'b1;
    // R8: outputs quiet during reset even with an active write request
    for (int i = 0; i < 3; i++) step(word_addr(BASE + NREG), 8'h01, 32'h123, 1'b1, "R8 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1, R4: write every register, upper data bits set
    for (int k = 0; k < NREG; k++) wr(k, 32'hA5A5_0000 | (32'h111 * (k + 1)), 1'b1, 1'b0, "R1 write");
    // R5: read back each, back-to-back
    for (int k = 0; k < NREG; k++) rd(k, 1'b1, "R5 readback");
    rd(0, 1'b1, "R5 tail");

    // R2: writes with done low leave values unchanged
    for (int k = 0; k < NREG; k++) wr(k, 32'h0000_0FFF, 1'b0, 1'b0, "R2 done low");
    for (int k = 0; k < NREG; k++) rd(k, 1'b0, "R2 readback");

    // R3: writes with memory-window bit set leave values unchanged
    for (int k = 0; k < NREG; k++) wr(k, 32'h0000_0555, 1'b1, 1'b1, "R3 mem bit");
    for (int k = 0; k < NREG; k++) rd(k, 1'b1, "R3 readback");

    // R1: strobe clear but other status bits set
    step(word_addr(BASE + 2), 8'hFE, 32'h0000_0777, 1'b1, "R1 no strobe");
    rd(2, 1'b1, "R1 readback");

    // R6: unmapped words on both sides and above the field
    step(word_addr(BASE - 1), 8'h00, 32'h0, 1'b1, "R6 below");
    step(word_addr(BASE + NREG + 1), 8'h00, 32'h0, 1'b1, "R6 above");
    step(word_addr(32'h0), 8'h00, 32'h0, 1'b1, "R6 zero");
    step(word_addr(BASE + NREG + 7), 8'h01, 32'hFFF, 1'b1, "R6 write unmapped");
    rd(1, 1'b1, "R6 settle");

    // R7: start slot with done toggling between address and data cycles
    step(word_addr(BASE + NREG), 8'h00, 32'h0, 1'b0, "R7 start a");
    step(word_addr(BASE + NREG), 8'h00, 32'h0, 1'b1, "R7 start b");
    step(word_addr(BASE + NREG), 8'h01, 32'hFFF, 1'b0, "R7 start c");
    rd(3, 1'b1, "R7 leave");
    rd(3, 1'b1, "R7 after");

    // Mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [ADDR_W-1:0] a;
      int unsigned w;
      w = BASE - 2 + ($urandom % (NREG + 5));
      a = word_addr(w);
      a[ADDR_W-1] = ($urandom % 6) == 0;
      step(a, STAT_W'($urandom), $urandom, ($urandom % 4) != 0, "R1 random");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule